// File: doc/BRIEF.md
# Hall-Commutated Fan Drive Sequencer

This block commutates a four-pole, single-coil brushless DC fan through an H-bridge of four FETs. A digitised Hall sensor bit enters through a two-flop synchroniser, and every change of the synchronised level, rising or falling, begins a new commutation phase. The sequencer steps through eight states: an even rotation of four phases followed by an odd rotation of four phases. At each phase start it drops every gate and waits out a dead interval. It then enables the high-side FET that matches the coil direction and routes an 8-bit PWM onto the low-side FET of the opposite leg.

Coil current near the tail of a phase produces little torque, so the low-side PWM is cut off a programmable margin before the predicted end of the phase. The prediction for each pole is taken from its own previously measured width, because the four poles are not evenly spaced. An outside measurement unit supplies the four widths, each with a valid flag. A pole with no valid width runs uncut. A pole whose width does not exceed the margin gets no low-side drive at all.

Top module: `fan_commutator`

## Requirements
- R1: After reset, `state` reads 7 (last odd phase) and all four gates are off. They stay off, whatever `duty`, `margin` and the widths are, until the first phase start.
- R2: A change of `hall_in` in either direction, held stable, starts a phase at the third rising clock edge after the change. `state` is unchanged before that edge and advances by one on it, modulo 8, so 7 wraps to 0. States 0–3 form the even rotation and 4–7 the odd rotation, and the pole index is `state[1:0]`.
- R3: All four gates are off on the phase-start edge and for the DEAD_CYC+1 cycles that begin there. A leg never has its high-side and low-side gates on together.
- R4: The gate bits are [0] high side A, [1] high side B, [2] low side A and [3] low side B. After the dead interval and until the next phase start, the high side A gate is on when `state[0]`=0 and the high side B gate is on when `state[0]`=1. The other high-side gate stays off.
- R5: The driven low side is bit [3] when `state[0]`=0 and bit [2] when `state[0]`=1, and the other low side stays off. Let m be the clocks elapsed between the phase-start edge and the edge before the output cycle. In each output cycle past the dead interval, the driven low side equals ((m / PWM_DIV) mod 256) < `duty`. The PWM count therefore restarts at every phase start, and `duty`=0 means never on.
- R6: When the current pole's width W is valid and W > `margin`, the low side is forced off once m ≥ W − `margin`.
- R7: When the current pole's valid flag is 0, the low side follows the R5 PWM for the whole phase, with no cutoff.
- R8: When the current pole's width is valid and W ≤ `margin`, the low side stays off for the whole phase, while the high side still follows R4.
- R9: The width and valid flag used in a phase are those of pole p = `state[1:0]`: bits [p*CNT_W +: CNT_W] of `pole_width` and bit p of `width_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_in | input | 1 | Asynchronous digitised Hall comparator output |
| duty | input | PWM_W (8) | Low-side PWM duty, in counts out of 256 |
| margin | input | CNT_W | Early cutoff margin in clocks |
| pole_width | input | 4*CNT_W | Last measured phase width of each pole, in clocks |
| width_ok | input | 4 | Valid flag for each pole's width |
| gate | output | 4 | FET enables {low B, low A, high B, high A} |
| state | output | 3 | Commutation state index, 0–3 even, 4–7 odd |

## Verification
A Hall change reaches `state` on the third rising edge after it, and the bench samples `state` at the falling edges that follow the first two edges, where it must still hold its old value, and at the falling edge after the third, where it must have advanced. The gate outputs are registered. The bench therefore indexes each phase by j, the count of rising edges since the phase-start edge, and compares the gates at the falling edge after edge j. It expects all gates off for j ≤ DEAD_CYC and computes the PWM and cutoff terms from m = j−1. Margin, duty, per-pole widths and valid flags are swept across both rotations, covering the boundary cases W = margin, W = margin+1, duty 0 and duty 255.

// File: rtl/fc_pkg.sv
// fc_pkg: shared constants for the fan commutation sequencer.
// Assumes a single-coil four-pole fan driven through an H-bridge whose
// gate enables are packed as {low B, low A, high B, high A}.
package fc_pkg;
    localparam int NPOLE   = 4;
    localparam int STATE_W = 3;
    localparam int GHA     = 0;
    localparam int GHB     = 1;
    localparam int GLA     = 2;
    localparam int GLB     = 3;

    typedef logic [STATE_W-1:0] seq_state_t;
endpackage

// File: rtl/fc_hall_sync.sv
// fc_hall_sync: brings the asynchronous Hall bit into the clock domain with
// two flops and flags one cycle on each change of the synchronised level.
// Assumes hall_in is low during reset; an input held high at reset release
// produces a single phase start.
module fc_hall_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_in,
    output logic phase_start
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    // Two-stage synchroniser plus previous-level register for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= hall_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Either polarity of a settled Hall change opens a new phase.
    assign phase_start = sync_q ^ last_q;
endmodule

// File: rtl/fc_phase_seq.sv
// fc_phase_seq: eight-state commutation sequencer. Holds the state index,
// the dead-interval counter and a saturating count of clocks since the
// current phase began. Assumes DEAD_CYC >= 1.
module fc_phase_seq
    import fc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DEAD_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_start,
    output seq_state_t       state,
    output logic             armed,
    output logic             dead,
    output logic [CNT_W-1:0] phase_cnt
);
    localparam int DEAD_W = $clog2(DEAD_CYC + 1);

    logic [DEAD_W-1:0] dead_cnt;

    // Advance the state, reload dead time and clear elapsed count per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= seq_state_t'(7);
            armed     <= 1'b0;
            dead_cnt  <= '0;
            phase_cnt <= '0;
        end else if (phase_start) begin
            state     <= state + seq_state_t'(1);
            armed     <= 1'b1;
            dead_cnt  <= DEAD_W'(DEAD_CYC);
            phase_cnt <= '0;
        end else begin
            if (dead_cnt != '0) begin
                dead_cnt <= dead_cnt - 1'b1;
            end
            if (phase_cnt != '1) begin
                phase_cnt <= phase_cnt + 1'b1;
            end
        end
    end

    // Dead interval is active while the reload is still counting down.
    assign dead = (dead_cnt != '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_start |=> (state == $past(state) + seq_state_t'(1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_start |=> $stable(state));

    p_dead_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_start |=> dead);
endmodule

// File: rtl/fc_pwm.sv
// fc_pwm: PWM_W-bit pulse generator whose count advances once every PWM_DIV
// clocks and restarts from zero on request, so that each phase sees the
// same pulse pattern. Output is high while count < duty.
module fc_pwm #(
    parameter int PWM_W   = 8,
    parameter int PWM_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PWM_W-1:0] duty,
    output logic             pwm_on
);
    logic             tick;
    logic [PWM_W-1:0] pwm_cnt;

    generate
        if (PWM_DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(PWM_DIV);
            logic [DIV_W-1:0] div_q;

            // Prescaler: one tick every PWM_DIV clocks, realigned on restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    div_q <= '0;
                end else if (div_q == DIV_W'(PWM_DIV - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == DIV_W'(PWM_DIV - 1));
        end
    endgenerate

    // Free-wrapping PWM counter, cleared at each phase start.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pwm_cnt <= '0;
        end else if (tick) begin
            pwm_cnt <= pwm_cnt + 1'b1;
        end
    end

    // Compare stage: on for the first duty counts of each period.
    assign pwm_on = (pwm_cnt < duty);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pwm_cnt == '0));
endmodule

// File: rtl/fan_commutator.sv
// fan_commutator: top of the Hall-commutated fan drive. Chooses the high
// side from the state parity, gates the PWM onto the opposite low side and
// cuts it off a margin before the end predicted by the current pole's
// stored width. Gate outputs are registered and forced off on every phase
// start. Assumes widths and margin are in clock cycles.
module fan_commutator
    import fc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PWM_W    = 8,
    parameter int PWM_DIV  = 4,
    parameter int DEAD_CYC = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hall_in,
    input  logic [PWM_W-1:0]       duty,
    input  logic [CNT_W-1:0]       margin,
    input  logic [NPOLE*CNT_W-1:0] pole_width,
    input  logic [NPOLE-1:0]       width_ok,
    output logic [3:0]             gate,
    output logic [STATE_W-1:0]     state
);
    logic             phase_start;
    seq_state_t       seq_state;
    logic             armed;
    logic             dead;
    logic [CNT_W-1:0] phase_cnt;
    logic             pwm_on;
    logic [1:0]       pole;
    logic [CNT_W-1:0] sel_width;
    logic             sel_ok;
    logic             too_short;
    logic             cut_allow;
    logic             drive_lo;
    logic [3:0]       gate_next;

    fc_hall_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .hall_in     (hall_in),
        .phase_start (phase_start)
    );

    fc_phase_seq #(
        .CNT_W    (CNT_W),
        .DEAD_CYC (DEAD_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_start (phase_start),
        .state       (seq_state),
        .armed       (armed),
        .dead        (dead),
        .phase_cnt   (phase_cnt)
    );

    fc_pwm #(
        .PWM_W   (PWM_W),
        .PWM_DIV (PWM_DIV)
    ) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_start),
        .duty    (duty),
        .pwm_on  (pwm_on)
    );

    // Per-pole width select and early-cutoff decision.
    always_comb begin
        pole      = seq_state[1:0];
        sel_width = pole_width[int'(pole)*CNT_W +: CNT_W];
        sel_ok    = width_ok[pole];
        too_short = (sel_width <= margin);
        if (!sel_ok) begin
            cut_allow = 1'b1;
        end else if (too_short) begin
            cut_allow = 1'b0;
        end else begin
            cut_allow = (phase_cnt < (sel_width - margin));
        end
        drive_lo = pwm_on && cut_allow;
    end

    // Bridge mapping: state parity picks the coil direction.
    always_comb begin
        gate_next = '0;
        if (armed && !dead) begin
            if (seq_state[0]) begin
                gate_next[GHB] = 1'b1;
                gate_next[GLA] = drive_lo;
            end else begin
                gate_next[GHA] = 1'b1;
                gate_next[GLB] = drive_lo;
            end
        end
    end

    // Registered gate stage, all FETs dropped on the phase-start edge.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_start) begin
            gate <= '0;
        end else begin
            gate <= gate_next;
        end
    end

    assign state = seq_state;

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (gate == '0));

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_start |=> (gate == '0));

    p_legs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate[GHA] && gate[GLA]) && !(gate[GHB] && gate[GLB]));

    p_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate[GHB], gate[GHA]}));

    p_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && too_short) |=> !(gate[GLA] || gate[GLB]));
endmodule

// File: tb/sim_fan_commutator.sv
module sim_fan_commutator;
    localparam int CNT_W = 16;
    localparam int DIV   = 2;
    localparam int DEAD  = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hall_in = 1'b0;
    logic [7:0]       duty = '0;
    logic [CNT_W-1:0] margin = '0;
    logic [4*CNT_W-1:0] pole_width = '0;
    logic [3:0]       width_ok = '0;
    logic [3:0]       gate;
    logic [2:0]       state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int wv [4];
    logic [2:0] exp_st = 3'd7;

    always #4 clk = ~clk;

    fan_commutator #(
        .CNT_W    (CNT_W),
        .PWM_W    (8),
        .PWM_DIV  (DIV),
        .DEAD_CYC (DEAD)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hall_in    (hall_in),
        .duty       (duty),
        .margin     (margin),
        .pole_width (pole_width),
        .width_ok   (width_ok),
        .gate       (gate),
        .state      (state)
    );

    task automatic chk(input bit good, input string tag, input int act, input int expv);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic set_widths(input int w0, input int w1, input int w2, input int w3,
                              input logic [3:0] ok);
        wv[0] = w0; wv[1] = w1; wv[2] = w2; wv[3] = w3;
        for (int p = 0; p < 4; p++) pole_width[p*CNT_W +: CNT_W] = CNT_W'(wv[p]);
        width_ok = ok;
    endtask

    // One phase: toggle Hall at a falling edge, then check every cycle.
    task automatic run_phase(input int len, input int d, input int mg, input string tag);
        logic [2:0] prev;
        duty    = 8'(d);
        margin  = CNT_W'(mg);
        prev    = exp_st;
        hall_in = ~hall_in;
        @(negedge clk);
        chk(state == prev, "R2", state, prev);
        @(negedge clk);
        chk(state == prev, "R2", state, prev);
        exp_st = exp_st + 3'd1;
        @(negedge clk);
        chk(state == exp_st, "R2", state, exp_st);
        chk(gate == 4'b0, "R3", gate, 0);
        for (int j = 1; j < len; j++) begin
            int m;
            logic [1:0] hs_e;
            logic lo_e;
            logic [1:0] p;
            bit allow;
            @(negedge clk);
            m = j - 1;
            p = exp_st[1:0];
            if (j <= DEAD) begin
                chk(gate == 4'b0, "R3", gate, 0);
            end else begin
                allow = (width_ok[p] == 1'b0) || ((wv[p] > mg) && (m < wv[p] - mg));
                lo_e  = (((m / DIV) % 256) < d) && allow;
                hs_e  = exp_st[0] ? 2'b10 : 2'b01;
                chk(gate[1:0] == hs_e, "R4", gate[1:0], hs_e);
                if (exp_st[0]) begin
                    chk(gate[3] == 1'b0, "R5", gate[3], 0);
                    chk(gate[2] == lo_e, tag, gate[2], lo_e);
                end else begin
                    chk(gate[2] == 1'b0, "R5", gate[2], 0);
                    chk(gate[3] == lo_e, tag, gate[3], lo_e);
                end
            end
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        duty  = 8'd200;
        set_widths(100, 100, 100, 100, 4'b1111);
        // R1: reset state and idle until the first Hall change.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(gate == 4'b0, "R1", gate, 0);
            chk(state == 3'd7, "R1", state, 7);
        end
        // R7: startup with no stored widths, full wrap of the eight states.
        set_widths(10, 10, 10, 10, 4'b0000);
        for (int k = 0; k < 9; k++) run_phase(300, 100, 5, "R7");
        // R9: distinct per-pole widths across both rotations.
        set_widths(150, 200, 250, 120, 4'b1111);
        for (int k = 0; k < 8; k++) run_phase(300, 200, 30, "R9");
        // R9: per-pole valid flags.
        set_widths(60, 60, 60, 60, 4'b0101);
        for (int k = 0; k < 8; k++) run_phase(200, 255, 10, "R9");
        // R8: width at or below margin on three poles.
        set_widths(150, 200, 250, 100, 4'b1111);
        for (int k = 0; k < 4; k++) run_phase(200, 255, 200, "R8");
        // R6: margin sweep around the width boundary.
        set_widths(150, 150, 150, 150, 4'b1111);
        foreach (wv[i]) begin end
        begin
            int mgs [8] = '{0, 1, 5, 100, 148, 149, 150, 151};
            foreach (mgs[i]) run_phase(200, 255, mgs[i], "R6");
        end
        // R5: duty sweep with no cutoff, across a full 256-step wrap.
        set_widths(0, 0, 0, 0, 4'b0000);
        begin
            int ds [8] = '{0, 1, 2, 127, 128, 200, 254, 255};
            foreach (ds[i]) run_phase(560, ds[i], 0, "R5");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule